// File: doc/BRIEF.md
# Monochrome Text-Mode Video Controller

This block produces 640x480, 60 Hz VGA raster timing from a pixel clock of about 25 MHz. It paints a 40-column by 20-row text page in a single colour. Character codes for the page and the 8x8 glyph bitmaps sit together in one 2048-byte dual-port memory. A host port on its own clock can read or overwrite any byte at any time. A host can therefore change the text and also redraw the font while the picture is running.

Each character cell is 16x24 pixels. Every glyph pixel is drawn two pixels wide and three lines tall. Bit 7 of a character code swaps foreground and background for that cell, and bits 6:0 select one of 128 glyphs. A glyph's eight row bytes start at code*8, with the most significant bit as the leftmost pixel.

The display side reads the memory twice for each cell: first the character code, then the glyph row byte. Sync and blank are delayed by the same number of clocks, so pixels stay lined up with the syncs. The single pixel bit may drive any one colour channel, or all three.

Top module: `mono_text_vga`

## Requirements
- R1: hsync_n is active low for H_SYNC clocks in every line of H_TOTAL = COLS*16 + H_FP + H_SYNC + H_BP clocks. It falls H_VIS + H_FP clocks after the first visible pixel of its line.
- R2: vsync_n is active low for V_SYNC whole lines in every frame of V_TOTAL = ROWS*24 + V_FP + V_SYNC + V_BP lines. It falls at the start of line V_VIS + V_FP.
- R3: blank is low exactly for pixel x < COLS*16 on line y < ROWS*24, and is high everywhere else, including every sync interval.
- R4: A visible pixel (x,y) is bit 7-((x mod 16)/2) of the byte at address code[6:0]*8 + (y mod 24)/3. Here code is the byte at SCREEN_BASE + (y/24)*COLS + x/16, and SCREEN_BASE is 848 by default.
- R5: When bit 7 of the cell's code is 1, every visible pixel of that cell is the inverse of the value R4 gives.
- R6: pix_out is 0 whenever blank is 1, whatever the code and glyph data.
- R7: While rst_n is low, the outputs are blank=1, hsync_n=1, vsync_n=1 and pix_out=0. These values hold for the first 4 pixel clocks after release. Pixel (0,0) appears in the 5th clock after release, and all outputs lag the internal raster by 4 clocks.
- R8: On a rising host_clk edge with host_we=1, the byte at host_addr takes host_wdata. The display shows the new value, glyph or code, from then on.
- R9: On a rising host_clk edge with host_we=0, host_rdata takes the byte at host_addr. On an edge with host_we=1, host_rdata keeps its value.
- R10: Addresses from SCREEN_BASE+COLS*ROWS up to 2047 hold host data and never change the picture.
- R11: Reset clears the raster counters only, and memory contents survive a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset of the display side |
| host_clk | input | 1 | Host port clock |
| host_we | input | 1 | Host write enable |
| host_addr | input | 11 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | High outside the visible area |
| pix_out | output | 1 | Monochrome pixel |

## Verification
A wrong raster counter shows up at the sync pins within one line: the hsync width or period is off for the next pulse. Vertical errors appear at the next vsync, at most one frame later. A mis-phased fetch pipeline leaves sync and blank correct but shifts or corrupts the pixels. It is visible in the first cell of the first visible line, five clocks after reset. A wrong glyph-row or inversion path shows only on pixels whose cell code or font byte exercises it. The bench therefore compares every pixel of whole frames against contents written through the host port, including codes that index glyphs lying inside the screen area.

// File: rtl/mtv_pkg.sv
package mtv_pkg;
  localparam int GLYPH_W    = 8;
  localparam int GLYPH_ROWS = 8;
  localparam int SCALE_X    = 2;
  localparam int SCALE_Y    = 3;
  localparam int CELL_W     = GLYPH_W * SCALE_X;
  localparam int CELL_H     = GLYPH_ROWS * SCALE_Y;
  localparam int MEM_AW     = 11;
  localparam int MEM_DW     = 8;
  localparam int PIPE_LAT   = 4;

  typedef struct packed {
    logic hsync_n;
    logic vsync_n;
    logic blank;
  } vid_ctl_t;

  localparam vid_ctl_t CTL_IDLE = '{hsync_n: 1'b1, vsync_n: 1'b1, blank: 1'b1};
endpackage

// File: rtl/mtv_dpram.sv
module mtv_dpram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          host_clk,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          disp_clk,
  input  logic [AW-1:0] disp_addr,
  output logic [DW-1:0] disp_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge host_clk) begin
    if (host_we) begin
      store[host_addr] <= host_wdata;
    end else begin
      host_rdata <= store[host_addr];
    end
  end

  always_ff @(posedge disp_clk) begin
    disp_rdata <= store[disp_addr];
  end
endmodule

// File: rtl/mtv_timing.sv
module mtv_timing
  import mtv_pkg::*;
#(
  parameter int COLS        = 40,
  parameter int ROWS        = 20,
  parameter int H_FP        = 16,
  parameter int H_SYNC      = 96,
  parameter int H_BP        = 48,
  parameter int V_FP        = 10,
  parameter int V_SYNC      = 2,
  parameter int V_BP        = 33,
  parameter int SCREEN_BASE = 848,
  localparam int H_VIS      = COLS * CELL_W,
  localparam int V_VIS      = ROWS * CELL_H,
  localparam int H_TOTAL    = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL    = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HW         = $clog2(H_TOTAL),
  localparam int VW         = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hcnt,
  output logic [2:0]    glyph_row,
  output logic [MEM_AW-1:0] row_addr,
  output vid_ctl_t      ctl
);
  logic [VW-1:0]     vcnt, vcnt_nxt;
  logic [HW-1:0]     hcnt_nxt;
  logic [1:0]        sub, sub_nxt;
  logic [2:0]        grow_nxt;
  logic [MEM_AW-1:0] row_addr_nxt;
  logic              line_end, frame_end;

  always_comb begin
    line_end     = (hcnt == HW'(H_TOTAL - 1));
    frame_end    = line_end && (vcnt == VW'(V_TOTAL - 1));
    hcnt_nxt     = line_end ? '0 : hcnt + 1'b1;
    vcnt_nxt     = vcnt;
    sub_nxt      = sub;
    grow_nxt     = glyph_row;
    row_addr_nxt = row_addr;
    if (frame_end) begin
      vcnt_nxt     = '0;
      sub_nxt      = '0;
      grow_nxt     = '0;
      row_addr_nxt = MEM_AW'(SCREEN_BASE);
    end else if (line_end) begin
      vcnt_nxt = vcnt + 1'b1;
      if (sub == 2'(SCALE_Y - 1)) begin
        sub_nxt = '0;
        if (glyph_row == 3'(GLYPH_ROWS - 1)) begin
          grow_nxt     = '0;
          row_addr_nxt = row_addr + MEM_AW'(COLS);
        end else begin
          grow_nxt = glyph_row + 1'b1;
        end
      end else begin
        sub_nxt = sub + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt      <= '0;
      vcnt      <= '0;
      sub       <= '0;
      glyph_row <= '0;
      row_addr  <= MEM_AW'(SCREEN_BASE);
    end else begin
      hcnt      <= hcnt_nxt;
      vcnt      <= vcnt_nxt;
      sub       <= sub_nxt;
      glyph_row <= grow_nxt;
      row_addr  <= row_addr_nxt;
    end
  end

  always_comb begin
    ctl.blank   = !((hcnt < HW'(H_VIS)) && (vcnt < VW'(V_VIS)));
    ctl.hsync_n = !((hcnt >= HW'(H_VIS + H_FP)) && (hcnt < HW'(H_VIS + H_FP + H_SYNC)));
    ctl.vsync_n = !((vcnt >= VW'(V_VIS + V_FP)) && (vcnt < VW'(V_VIS + V_FP + V_SYNC)));
  end
endmodule

// File: rtl/mtv_render.sv
module mtv_render
  import mtv_pkg::*;
#(
  parameter int HW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HW-1:0]     hcnt,
  input  logic [2:0]        glyph_row,
  input  logic [MEM_AW-1:0] row_addr,
  input  vid_ctl_t          ctl_in,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [MEM_DW-1:0] mem_data,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              blank,
  output logic              pix_out
);
  localparam int PW = $clog2(CELL_W);

  logic [PW-1:0]     phase, sub_x;
  logic              ld_code, ld_pat;
  logic              inv_q, inv_nxt;
  logic              pat_inv, pat_inv_nxt;
  logic [MEM_DW-1:0] pat, pat_nxt;
  logic              pix_nxt;
  vid_ctl_t          ctl_pipe [PIPE_LAT];

  always_comb begin
    phase    = hcnt[PW-1:0];
    ld_code  = (phase == PW'(1));
    ld_pat   = (phase == PW'(2));
    mem_addr = ld_code ? {mem_data[6:0], glyph_row, 1'b0} >> 1
                       : row_addr + MEM_AW'(hcnt[HW-1:PW]);
    inv_nxt     = ld_code ? mem_data[7] : inv_q;
    pat_nxt     = ld_pat  ? mem_data    : pat;
    pat_inv_nxt = ld_pat  ? inv_q       : pat_inv;
    sub_x       = phase - PW'(3);
    pix_nxt     = ctl_pipe[PIPE_LAT-2].blank ? 1'b0
                : (pat[~sub_x[PW-1:1]] ^ pat_inv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_q   <= 1'b0;
      pat     <= '0;
      pat_inv <= 1'b0;
      pix_out <= 1'b0;
    end else begin
      inv_q   <= inv_nxt;
      pat     <= pat_nxt;
      pat_inv <= pat_inv_nxt;
      pix_out <= pix_nxt;
    end
  end

  generate
    for (genvar s = 0; s < PIPE_LAT; s++) begin : g_ctl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ctl_pipe[s] <= CTL_IDLE;
        end else if (s == 0) begin
          ctl_pipe[s] <= ctl_in;
        end else begin
          ctl_pipe[s] <= ctl_pipe[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign hsync_n = ctl_pipe[PIPE_LAT-1].hsync_n;
  assign vsync_n = ctl_pipe[PIPE_LAT-1].vsync_n;
  assign blank   = ctl_pipe[PIPE_LAT-1].blank;
endmodule

// File: rtl/mono_text_vga.sv
module mono_text_vga
  import mtv_pkg::*;
#(
  parameter int COLS        = 40,
  parameter int ROWS        = 20,
  parameter int H_FP        = 16,
  parameter int H_SYNC      = 96,
  parameter int H_BP        = 48,
  parameter int V_FP        = 10,
  parameter int V_SYNC      = 2,
  parameter int V_BP        = 33,
  parameter int SCREEN_BASE = 848,
  localparam int H_VIS      = COLS * CELL_W,
  localparam int V_VIS      = ROWS * CELL_H,
  localparam int H_TOTAL    = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL    = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HW         = $clog2(H_TOTAL)
) (
  input  logic        pix_clk,
  input  logic        rst_n,
  input  logic        host_clk,
  input  logic        host_we,
  input  logic [10:0] host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        hsync_n,
  output logic        vsync_n,
  output logic        blank,
  output logic        pix_out
);
  logic [HW-1:0]     hcnt;
  logic [2:0]        glyph_row;
  logic [MEM_AW-1:0] row_addr;
  logic [MEM_AW-1:0] disp_addr;
  logic [MEM_DW-1:0] disp_data;
  vid_ctl_t          ctl;

  mtv_timing #(
    .COLS(COLS), .ROWS(ROWS),
    .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .SCREEN_BASE(SCREEN_BASE)
  ) u_timing (
    .clk(pix_clk), .rst_n(rst_n),
    .hcnt(hcnt), .glyph_row(glyph_row), .row_addr(row_addr), .ctl(ctl)
  );

  mtv_render #(.HW(HW)) u_render (
    .clk(pix_clk), .rst_n(rst_n),
    .hcnt(hcnt), .glyph_row(glyph_row), .row_addr(row_addr), .ctl_in(ctl),
    .mem_addr(disp_addr), .mem_data(disp_data),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .blank(blank), .pix_out(pix_out)
  );

  mtv_dpram #(.AW(MEM_AW), .DW(MEM_DW)) u_mem (
    .host_clk(host_clk), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .disp_clk(pix_clk), .disp_addr(disp_addr), .disp_rdata(disp_data)
  );
endmodule

// File: rtl/mtv_checker.sv
module mtv_checker #(
  parameter int H_SYNC  = 96,
  parameter int H_TOTAL = 800,
  parameter int V_SYNC  = 2,
  parameter int V_TOTAL = 525,
  localparam int FRAME  = H_TOTAL * V_TOTAL,
  localparam int CW     = $clog2(FRAME + 2)
) (
  input logic       pix_clk,
  input logic       rst_n,
  input logic       host_clk,
  input logic       host_we,
  input logic [7:0] host_rdata,
  input logic       hsync_n,
  input logic       vsync_n,
  input logic       blank,
  input logic       pix_out
);
  logic          hs_prev, vs_prev, hs_seen, vs_seen;
  logic [CW-1:0] hs_low, hs_per, vs_low, vs_per;

  always_ff @(posedge pix_clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_prev <= 1'b1; vs_prev <= 1'b1;
      hs_seen <= 1'b0; vs_seen <= 1'b0;
      hs_low  <= '0;   hs_per  <= '0;
      vs_low  <= '0;   vs_per  <= '0;
    end else begin
      hs_prev <= hsync_n;
      vs_prev <= vsync_n;
      hs_low  <= hsync_n ? '0 : hs_low + 1'b1;
      vs_low  <= vsync_n ? '0 : vs_low + 1'b1;
      if (hs_prev && !hsync_n) begin
        hs_per  <= CW'(1);
        hs_seen <= 1'b1;
      end else begin
        hs_per <= hs_per + 1'b1;
      end
      if (vs_prev && !vsync_n) begin
        vs_per  <= CW'(1);
        vs_seen <= 1'b1;
      end else begin
        vs_per <= vs_per + 1'b1;
      end
    end
  end

  p_hsync_width_r1: assert property (@(posedge pix_clk) disable iff (!rst_n)
    (hsync_n && !hs_prev) |-> (hs_low == CW'(H_SYNC)));

  p_line_period_r1: assert property (@(posedge pix_clk) disable iff (!rst_n)
    (!hsync_n && hs_prev && hs_seen) |-> (hs_per == CW'(H_TOTAL)));

  p_vsync_width_r2: assert property (@(posedge pix_clk) disable iff (!rst_n)
    (vsync_n && !vs_prev) |-> (vs_low == CW'(V_SYNC * H_TOTAL)));

  p_frame_period_r2: assert property (@(posedge pix_clk) disable iff (!rst_n)
    (!vsync_n && vs_prev && vs_seen) |-> (vs_per == CW'(FRAME)));

  p_sync_blanked_r3: assert property (@(posedge pix_clk) disable iff (!rst_n)
    (!hsync_n || !vsync_n) |-> blank);

  p_dark_in_blank_r6: assert property (@(posedge pix_clk) disable iff (!rst_n)
    blank |-> !pix_out);

  p_rdata_hold_r9: assert property (@(posedge host_clk) disable iff (!rst_n)
    host_we |=> $stable(host_rdata));
endmodule

bind mono_text_vga mtv_checker #(
  .H_SYNC(H_SYNC), .H_TOTAL(H_TOTAL), .V_SYNC(V_SYNC), .V_TOTAL(V_TOTAL)
) u_chk (
  .pix_clk(pix_clk), .rst_n(rst_n), .host_clk(host_clk), .host_we(host_we),
  .host_rdata(host_rdata), .hsync_n(hsync_n), .vsync_n(vsync_n),
  .blank(blank), .pix_out(pix_out)
);

// File: tb/sim_mono_text_vga.sv
module sim_mono_text_vga;
  localparam int COLS = 4, ROWS = 2;
  localparam int HFP = 4, HSY = 8, HBP = 4;
  localparam int VFP = 2, VSY = 2, VBP = 2;
  localparam int BASE = 848;
  localparam int HV = COLS * 16, VV = ROWS * 24;
  localparam int HT = HV + HFP + HSY + HBP;
  localparam int VT = VV + VFP + VSY + VBP;
  localparam int FRAME = HT * VT;
  localparam int SCRATCH = BASE + COLS * ROWS;

  // entry: 8 cell codes (cell 0 in the top byte), patch address, patch data
  localparam logic [82:0] TBL [4] = '{
    {64'h41424344_C1007F80, 11'd523,  8'hA5},
    {64'h00000000_00000000, 11'd2,    8'hFF},
    {64'h80808080_80808080, 11'd856,  8'h3C},
    {64'h6AEB1293_6B6CEDEE, 11'd2047, 8'h5A}
  };

  logic       pix_clk = 1'b0, host_clk = 1'b0, rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic [10:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic       hsync_n, vsync_n, blank, pix_out;
  logic [7:0] mdl [2048];
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 pix_clk = ~pix_clk;
  always #7  host_clk = ~host_clk;

  mono_text_vga #(
    .COLS(COLS), .ROWS(ROWS), .H_FP(HFP), .H_SYNC(HSY), .H_BP(HBP),
    .V_FP(VFP), .V_SYNC(VSY), .V_BP(VBP), .SCREEN_BASE(BASE)
  ) u0 (
    .pix_clk(pix_clk), .rst_n(rst_n), .host_clk(host_clk), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .blank(blank), .pix_out(pix_out)
  );

  task automatic host_wr(input int a, input logic [7:0] d);
    @(negedge host_clk);
    host_we = 1'b1; host_addr = 11'(a); host_wdata = d;
    @(posedge host_clk); #1;
    host_we = 1'b0;
    mdl[a] = d;
  endtask

  task automatic host_rd(input int a, output logic [7:0] d);
    @(negedge host_clk);
    host_we = 1'b0; host_addr = 11'(a);
    @(posedge host_clk); #1;
    d = host_rdata;
  endtask

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected outputs at cycle t after reset release (t=0 is the first cycle)
  task automatic cmp(input int t);
    logic ebl, ehs, evs, epx;
    logic [7:0] code, gb;
    int u, h, v;
    string tag;
    code = 8'h00;
    if (t < 4) begin
      ebl = 1; ehs = 1; evs = 1; epx = 0;           // R7
    end else begin
      u = t - 4; h = u % HT; v = (u / HT) % VT;
      ebl = !(h < HV && v < VV);                     // R3
      ehs = !(h >= HV + HFP && h < HV + HFP + HSY);  // R1
      evs = !(v >= VV + VFP && v < VV + VFP + VSY);  // R2
      if (ebl) epx = 0;                              // R6
      else begin
        code = mdl[BASE + (v / 24) * COLS + h / 16]; // R4
        gb   = mdl[code[6:0] * 8 + (v % 24) / 3];
        epx  = gb[7 - (h % 16) / 2] ^ code[7];       // R5
      end
    end
    checks++;
    if (hsync_n !== ehs || vsync_n !== evs || blank !== ebl || pix_out !== epx) begin
      errors++;
      if (t < 4) tag = "R7";
      else if (hsync_n !== ehs) tag = "R1";
      else if (vsync_n !== evs) tag = "R2";
      else if (blank !== ebl) tag = "R3";
      else if (ebl) tag = "R6";
      else if (code[7]) tag = "R5";
      else tag = "R4";
      $display("FAIL %s t=%0d actual hs=%b vs=%b bl=%b px=%b expected hs=%b vs=%b bl=%b px=%b",
               tag, t, hsync_n, vsync_n, blank, pix_out, ehs, evs, ebl, epx);
    end
  endtask

  task automatic run_frame(input int ncyc);
    @(negedge pix_clk);
    rst_n = 1'b1;
    #1 cmp(0);
    for (int t = 1; t <= ncyc; t++) begin
      @(posedge pix_clk);
      @(negedge pix_clk);
      cmp(t);
    end
  endtask

  initial begin
    logic [7:0] rd;
    // R7: outputs idle while reset is held
    #25;
    checks++;
    if (blank !== 1 || hsync_n !== 1 || vsync_n !== 1 || pix_out !== 0) begin
      errors++;
      $display("FAIL R7 reset outputs actual %b%b%b%b expected 1110",
               blank, hsync_n, vsync_n, pix_out);
    end
    // fill the whole memory (R8)
    for (int a = 0; a < 2048; a++) host_wr(a, 8'((a * 73 + (a >> 3)) & 255));
    host_rd(523, rd);        chk8("R9 readback glyph", rd, mdl[523]);
    host_rd(BASE, rd);       chk8("R9 readback screen", rd, mdl[BASE]);
    host_rd(2047, rd);       chk8("R10 readback scratch", rd, mdl[2047]);
    // R9: read data holds through a write
    host_rd(100, rd);
    host_wr(101, ~mdl[100]);
    chk8("R9 rdata held during write", host_rdata, mdl[100]);
    host_rd(101, rd);        chk8("R8 written byte", rd, mdl[101]);

    for (int e = 0; e < 4; e++) begin
      @(negedge pix_clk);
      rst_n = 1'b0;           // R11: reset mid-run, memory must survive
      for (int c = 0; c < 8; c++) host_wr(BASE + c, TBL[e][82 - 8*c -: 8]);
      host_wr(int'(TBL[e][18:8]), TBL[e][7:0]);  // R8 glyph rewrite / R10 scratch
      host_rd(int'(TBL[e][18:8]), rd);
      chk8("R8 patch readback", rd, TBL[e][7:0]);
      host_rd(SCRATCH, rd);
      chk8("R11 contents kept over reset", rd, mdl[SCRATCH]);
      run_frame(4 + FRAME + 2 * HT);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule